// File: doc/BRIEF.md
# Banked Address Decoder

This block sits between a CPU with a 24-bit byte address and the memories and peripherals behind it. The top four address bits pick one of sixteen 1 MiB regions. For each accepted request the block raises the chip select of that region, one cycle later, together with a local address. The local address is trimmed to the size of the device behind the select. Seven regions are populated: program ROM (0), work RAM (1), banked cartridge ROM (2), I/O (3), palette (4), BIOS ROM (0xC) and backup RAM (0xD). The other nine are empty.

Region 2 shows a 1 MiB window into a larger cartridge ROM. A 3-bit bank register picks the window, and the CPU loads it by writing into the top sixteen bytes of the region. One fixed byte address just below that window is answered by the decoder itself with the current bank number. Reads of empty regions are also answered locally, with an all-ones pattern. Writes that nothing can accept are dropped and flagged. A 32-bit access to the I/O region is split into two 16-bit accesses on consecutive cycles. The decoder refuses new requests while the second half is going out. Data is big-endian: the byte at the lower address is the most significant.

Top module: `adr_banked_decoder`

## Requirements
- R1: A request accepted at a clock edge (`req_valid` high while `req_ready` is high) drives its result on the outputs for exactly the following cycle. A forwarded access raises `out_valid` and exactly one bit of `out_sel`, the bit numbered by `req_addr[23:20]`. Only regions 0, 1, 2, 3, 4, 12 and 13 are ever selected. After reset all outputs are low and `req_ready` is high.
- R2: The local address on `out_addr` keeps 20 offset bits for regions 0, 3 and 4, 16 bits for regions 1 and 13, and 17 bits for region 12. All higher bits are zero.
- R3: Any write with an address from 0x2FFFF0 to 0x2FFFFF loads the bank register with `req_wdata[2:0]`, for every access size. It raises no select, no response and no flag, and the new value applies from the next accepted request. The bank resets to 0.
- R4: A forwarded region-2 access drives `out_addr[22:20]` with the bank and `out_addr[19:0]` with `req_addr[19:0]`.
- R5: A byte read (size code 0) of 0x2FFFEF raises `resp_valid` with `resp_data` equal to the zero-extended bank, and selects nothing. Wider reads at that address go to the ROM.
- R6: A write to region 0, region 12, an empty region, or region 2 outside the bank window raises `unk_wr` for one cycle. It selects nothing and changes no state.
- R7: A read of an empty region raises `resp_valid` with `resp_data` = 0x000000FF for a byte, 0x0000FFFF for a word (size code 1), and 0 for a longword (size code 2).
- R8: A longword access to region 3 is sent as two word accesses on consecutive cycles. The first goes to the request address with `req_wdata[31:16]` in `out_wdata[15:0]` and `req_ready` low. The second goes to the address plus 2 with `req_wdata[15:0]`. A request presented while `req_ready` is low is ignored.
- R9: A word or longword request with `req_addr[0]` set raises `align_err` for one cycle. Nothing is selected, no response is given and the bank is not changed.
- R10: A forwarded access that is not split carries `req_size`, `req_we` and the full `req_wdata` unchanged to `out_size`, `out_we` and `out_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_addr | input | 24 | CPU byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_we | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned |
| req_ready | output | 1 | Low while the second half of a split access is pending |
| out_valid | output | 1 | Forwarded access this cycle |
| out_sel | output | 16 | One-hot region select |
| out_addr | output | 23 | Local address, bank in the top three bits for region 2 |
| out_size | output | 2 | Size of the forwarded access |
| out_we | output | 1 | Forwarded write |
| out_wdata | output | 32 | Forwarded write data |
| resp_valid | output | 1 | Decoder answers a read itself |
| resp_data | output | 32 | Local read answer |
| unk_wr | output | 1 | Write dropped |
| align_err | output | 1 | Misaligned request dropped |

## Verification
The hardest situation to reach is a request that arrives during the second half of a split I/O longword. It must leave no trace, and from the ports it is visible only as the absence of an access in the next cycle. The stimulus presents a live ROM read in the very cycle `req_ready` is low. It then checks the following cycle for an idle output. The bank register has no output of its own. So every claim that a misaligned or rejected write left the bank alone is checked through the read-back byte at 0x2FFFEF.

// File: rtl/adr_pkg.sv
package adr_pkg;
    localparam int ADDR_W   = 24;
    localparam int DATA_W   = 32;
    localparam int HALF_W   = DATA_W / 2;
    localparam int REGION_W = 4;
    localparam int NREG     = 1 << REGION_W;
    localparam int OFF_W    = ADDR_W - REGION_W;
    localparam int BANK_W   = 3;
    localparam int LOC_W    = OFF_W + BANK_W;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    localparam logic [REGION_W-1:0] IO_REGION   = 4'h3;
    localparam logic [OFF_W-1:0]    BANK_WIN    = 20'hFFFF0;
    localparam logic [OFF_W-1:0]    BANK_RD_OFF = 20'hFFFEF;
    localparam int                  WIN_LSB     = 4;

    typedef enum logic [2:0] {
        RK_NONE, RK_ROM, RK_RAM, RK_BANK, RK_IO, RK_PAL
    } kind_e;

    typedef struct packed {
        logic              valid;
        logic [NREG-1:0]   sel;
        logic [LOC_W-1:0]  addr;
        logic [1:0]        size;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              unk;
        logic              aerr;
        logic              split;
        logic [OFF_W-1:0]  sp_off;
        logic              sp_we;
        logic [HALF_W-1:0] sp_data;
    } dec_state_t;
endpackage

// File: rtl/adr_region_map.sv
module adr_region_map
    import adr_pkg::*;
#(
    parameter int ROM_W  = 20,
    parameter int WRAM_W = 16,
    parameter int BIOS_W = 17,
    parameter int BRAM_W = 16
) (
    input  logic [REGION_W-1:0] idx,
    output kind_e               kind,
    output logic [OFF_W-1:0]    mask
);
    localparam logic [OFF_W-1:0] ROM_M  = OFF_W'((64'd1 << ROM_W) - 1);
    localparam logic [OFF_W-1:0] WRAM_M = OFF_W'((64'd1 << WRAM_W) - 1);
    localparam logic [OFF_W-1:0] BIOS_M = OFF_W'((64'd1 << BIOS_W) - 1);
    localparam logic [OFF_W-1:0] BRAM_M = OFF_W'((64'd1 << BRAM_W) - 1);
    localparam logic [OFF_W-1:0] FULL_M = '1;

    always_comb begin
        kind = RK_NONE;
        mask = '0;
        case (idx)
            4'h0: begin kind = RK_ROM;  mask = ROM_M;  end
            4'h1: begin kind = RK_RAM;  mask = WRAM_M; end
            4'h2: begin kind = RK_BANK; mask = FULL_M; end
            4'h3: begin kind = RK_IO;   mask = FULL_M; end
            4'h4: begin kind = RK_PAL;  mask = FULL_M; end
            4'hC: begin kind = RK_ROM;  mask = BIOS_M; end
            4'hD: begin kind = RK_RAM;  mask = BRAM_M; end
            default: begin kind = RK_NONE; mask = '0; end
        endcase
    end
endmodule

// File: rtl/adr_bank_reg.sv
module adr_bank_reg
    import adr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load) bank_d = din;
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    assign bank = bank_q;
endmodule

// File: rtl/adr_banked_decoder.sv
module adr_banked_decoder
    import adr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [23:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_we,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              out_valid,
    output logic [15:0]       out_sel,
    output logic [22:0]       out_addr,
    output logic [1:0]        out_size,
    output logic              out_we,
    output logic [31:0]       out_wdata,
    output logic              resp_valid,
    output logic [31:0]       resp_data,
    output logic              unk_wr,
    output logic              align_err
);
    dec_state_t          st_d, st_q;
    logic [REGION_W-1:0] idx;
    logic [OFF_W-1:0]    off;
    logic [OFF_W-1:0]    mask;
    kind_e               kind;
    logic [BANK_W-1:0]   bank_num;
    logic                bank_ld;
    logic                in_win;

    assign idx    = req_addr[ADDR_W-1:OFF_W];
    assign off    = req_addr[OFF_W-1:0];
    assign in_win = off[OFF_W-1:WIN_LSB] == BANK_WIN[OFF_W-1:WIN_LSB];

    adr_region_map u_map (
        .idx  (idx),
        .kind (kind),
        .mask (mask)
    );

    adr_bank_reg u_bank (
        .clk  (clk),
        .rst  (rst),
        .load (bank_ld),
        .din  (req_wdata[BANK_W-1:0]),
        .bank (bank_num)
    );

    always_comb begin
        st_d    = '0;
        bank_ld = 1'b0;
        if (st_q.split) begin
            // second half of a split I/O longword; new requests are ignored
            st_d.valid          = 1'b1;
            st_d.sel[IO_REGION] = 1'b1;
            st_d.addr           = LOC_W'(st_q.sp_off);
            st_d.size           = SZ_WORD;
            st_d.we             = st_q.sp_we;
            st_d.wdata          = DATA_W'(st_q.sp_data);
        end else if (req_valid) begin
            if (req_size != SZ_BYTE && req_addr[0]) begin
                st_d.aerr = 1'b1;
            end else if (kind == RK_NONE) begin
                if (req_we) begin
                    st_d.unk = 1'b1;
                end else begin
                    st_d.rvalid = 1'b1;
                    case (req_size)
                        SZ_BYTE: st_d.rdata = DATA_W'(8'hFF);
                        SZ_WORD: st_d.rdata = DATA_W'(16'hFFFF);
                        default: st_d.rdata = '0;
                    endcase
                end
            end else if (kind == RK_BANK && req_we) begin
                if (in_win) bank_ld   = 1'b1;
                else        st_d.unk  = 1'b1;
            end else if (kind == RK_ROM && req_we) begin
                st_d.unk = 1'b1;
            end else if (kind == RK_BANK && req_size == SZ_BYTE && off == BANK_RD_OFF) begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = DATA_W'(bank_num);
            end else if (kind == RK_IO && req_size == SZ_LONG) begin
                st_d.valid    = 1'b1;
                st_d.sel[idx] = 1'b1;
                st_d.addr     = LOC_W'(off & mask);
                st_d.size     = SZ_WORD;
                st_d.we       = req_we;
                st_d.wdata    = DATA_W'(req_wdata[DATA_W-1:HALF_W]);
                st_d.split    = 1'b1;
                st_d.sp_off   = off + OFF_W'(2);
                st_d.sp_we    = req_we;
                st_d.sp_data  = req_wdata[HALF_W-1:0];
            end else begin
                st_d.valid    = 1'b1;
                st_d.sel[idx] = 1'b1;
                st_d.size     = req_size;
                st_d.we       = req_we;
                st_d.wdata    = req_wdata;
                if (kind == RK_BANK) st_d.addr = {bank_num, off};
                else                 st_d.addr = LOC_W'(off & mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req_ready  = !st_q.split;
    assign out_valid  = st_q.valid;
    assign out_sel    = st_q.sel;
    assign out_addr   = st_q.addr;
    assign out_size   = st_q.size;
    assign out_we     = st_q.we;
    assign out_wdata  = st_q.wdata;
    assign resp_valid = st_q.rvalid;
    assign resp_data  = st_q.rdata;
    assign unk_wr     = st_q.unk;
    assign align_err  = st_q.aerr;
endmodule

// File: rtl/adr_banked_decoder_chk.sv
module adr_banked_decoder_chk
    import adr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              out_valid,
    input logic [15:0]       out_sel,
    input logic [22:0]       out_addr,
    input logic [1:0]        out_size,
    input logic              resp_valid,
    input logic              unk_wr,
    input logic              align_err,
    input logic [BANK_W-1:0] bank_num
);
    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_sel));

    a_r1_valid_matches_sel: assert property (@(posedge clk) disable iff (rst)
        out_valid == (out_sel != '0));

    a_r1_no_empty_region: assert property (@(posedge clk) disable iff (rst)
        (out_sel & 16'hCFE0) == '0);

    a_r4_bank_in_addr: assert property (@(posedge clk) disable iff (rst)
        out_sel[2] |-> out_addr[LOC_W-1:OFF_W] == bank_num);

    a_r6_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
        unk_wr |-> !out_valid && !resp_valid && $stable(bank_num));

    a_r9_misaligned_quiet: assert property (@(posedge clk) disable iff (rst)
        align_err |-> !out_valid && !resp_valid && $stable(bank_num));

    a_r8_second_half: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> out_valid && out_sel == 16'h0008 && out_size == SZ_WORD
                       && out_addr[OFF_W-1:0] == $past(out_addr[OFF_W-1:0]) + OFF_W'(2));

    a_r8_single_stall: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);
endmodule

bind adr_banked_decoder adr_banked_decoder_chk u_chk (.*);

// File: tb/adr_banked_decoder_tb.sv
module adr_banked_decoder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [23:0] req_addr;
    logic [1:0]  req_size;
    logic        req_we;
    logic [31:0] req_wdata;
    logic        req_ready, out_valid, out_we, resp_valid, unk_wr, align_err;
    logic [15:0] out_sel;
    logic [22:0] out_addr;
    logic [1:0]  out_size;
    logic [31:0] out_wdata, resp_data;

    always #5 clk = ~clk;

    adr_banked_decoder u_dut (.*);

    typedef struct {
        logic        valid;
        logic [15:0] sel;
        logic [22:0] addr;
        logic [1:0]  size;
        logic        we;
        logic [31:0] wdata;
        logic        rvalid;
        logic [31:0] rdata;
        logic        unk;
        logic        aerr;
        logic        ready;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   nchk  = 0;
    int   nfail = 0;
    bit   done  = 1'b0;

    function automatic exp_t idle(string tag);
        exp_t e;
        e.valid = 0; e.sel = 0; e.addr = 0; e.size = 0; e.we = 0; e.wdata = 0;
        e.rvalid = 0; e.rdata = 0; e.unk = 0; e.aerr = 0; e.ready = 1; e.tag = tag;
        return e;
    endfunction

    function automatic exp_t acc(string tag, int r, logic [22:0] a, logic [1:0] sz,
                                 logic we, logic [31:0] wd);
        exp_t e = idle(tag);
        e.valid = 1; e.sel = 16'(1) << r; e.addr = a; e.size = sz; e.we = we; e.wdata = wd;
        return e;
    endfunction

    function automatic exp_t resp(string tag, logic [31:0] d);
        exp_t e = idle(tag);
        e.rvalid = 1; e.rdata = d;
        return e;
    endfunction

    function automatic exp_t flag(string tag, bit aerr);
        exp_t e = idle(tag);
        if (aerr) e.aerr = 1; else e.unk = 1;
        return e;
    endfunction

    function automatic string show(logic v, logic [15:0] s, logic [22:0] a, logic [1:0] z,
                                   logic w, logic [31:0] wd, logic rv, logic [31:0] rd,
                                   logic u, logic ae, logic rdy);
        return $sformatf("v=%0b sel=%04h a=%06h sz=%0d we=%0b wd=%08h rv=%0b rd=%08h unk=%0b ae=%0b rdy=%0b",
                         v, s, a, z, w, wd, rv, rd, u, ae, rdy);
    endfunction

    function automatic void compare(exp_t e);
        string act, ex;
        act = show(out_valid, out_sel, out_addr, out_size, out_we, out_wdata,
                   resp_valid, resp_data, unk_wr, align_err, req_ready);
        ex  = show(e.valid, e.sel, e.addr, e.size, e.we, e.wdata,
                   e.rvalid, e.rdata, e.unk, e.aerr, e.ready);
        nchk++;
        if (act != ex) begin
            nfail++;
            $display("FAIL %s: got %s expected %s", e.tag, act, ex);
        end
    endfunction

    task automatic drive(logic v, logic [23:0] a, logic [1:0] sz, logic we,
                         logic [31:0] wd, exp_t e);
        @(negedge clk);
        req_valid = v; req_addr = a; req_size = sz; req_we = we; req_wdata = wd;
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                compare(e);
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; req_valid = 0; req_addr = 0; req_size = 0; req_we = 0; req_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        compare(idle("R1 reset state"));

        // R1 / R2 / R10: region selects and local address masks
        drive(1, 24'h012345, 2'd0, 0, 32'h0,        acc("R1 rom byte read", 0, 23'h012345, 2'd0, 0, 32'h0));
        drive(1, 24'h1ABCDE, 2'd1, 0, 32'h0,        acc("R2 work ram 16-bit mask", 1, 23'h00BCDE, 2'd1, 0, 32'h0));
        drive(1, 24'hC3FFF0, 2'd2, 0, 32'h0,        acc("R2 bios 17-bit mask", 12, 23'h01FFF0, 2'd2, 0, 32'h0));
        drive(1, 24'hD12344, 2'd1, 1, 32'h0000BEEF, acc("R2 backup ram write", 13, 23'h002344, 2'd1, 1, 32'h0000BEEF));
        drive(1, 24'h4ABCDE, 2'd0, 1, 32'hCAFE005A, acc("R10 palette byte write", 4, 23'h0ABCDE, 2'd0, 1, 32'hCAFE005A));

        // R4 / R5 / R3: banking
        drive(1, 24'h2ABCDE, 2'd0, 0, 32'h0, acc("R4 bank 0 after reset", 2, 23'h0ABCDE, 2'd0, 0, 32'h0));
        drive(1, 24'h2FFFEF, 2'd0, 0, 32'h0, resp("R5 readback bank 0", 32'd0));
        drive(1, 24'h2FFFF3, 2'd0, 1, 32'h000000FD, idle("R3 window byte write silent"));
        drive(1, 24'h2FFFEF, 2'd0, 0, 32'h0, resp("R3 bank loaded with 5", 32'd5));
        drive(1, 24'h2ABCDC, 2'd1, 0, 32'h0, acc("R4 bank 5 word read", 2, 23'h5ABCDC, 2'd1, 0, 32'h0));
        drive(1, 24'h2FFFFC, 2'd2, 1, 32'h0000000A, idle("R3 window long write silent"));
        drive(1, 24'h2FFFEE, 2'd1, 0, 32'h0, acc("R5 word at readback goes to rom", 2, 23'h2FFFEE, 2'd1, 0, 32'h0));

        // R9: misalignment
        drive(1, 24'h2FFFF1, 2'd1, 1, 32'h00000007, flag("R9 misaligned window write", 1));
        drive(1, 24'h2FFFEF, 2'd0, 0, 32'h0, resp("R9 bank still 2", 32'd2));
        drive(1, 24'h100001, 2'd2, 0, 32'h0, flag("R9 misaligned long read", 1));

        // R6: dropped writes
        drive(1, 24'h000010, 2'd1, 1, 32'h00001234, flag("R6 rom write", 0));
        drive(1, 24'hC00000, 2'd0, 1, 32'h00000001, flag("R6 bios write", 0));
        drive(1, 24'h900000, 2'd0, 1, 32'h00000001, flag("R6 empty region write", 0));
        drive(1, 24'h212340, 2'd1, 1, 32'h00000006, flag("R6 banked write outside window", 0));
        drive(1, 24'h2FFFEF, 2'd0, 0, 32'h0, resp("R6 bank unchanged", 32'd2));

        // R7: empty region reads
        drive(1, 24'h5ABCDE, 2'd0, 0, 32'h0, resp("R7 empty byte read", 32'h000000FF));
        drive(1, 24'hF00002, 2'd1, 0, 32'h0, resp("R7 empty word read", 32'h0000FFFF));
        drive(1, 24'h800000, 2'd2, 0, 32'h0, resp("R7 empty long read", 32'h00000000));

        // R8: split I/O longwords
        begin
            exp_t e = acc("R8 io long read first half", 3, 23'h0C0000, 2'd1, 0, 32'h0);
            e.ready = 0;
            drive(1, 24'h3C0000, 2'd2, 0, 32'h0, e);
        end
        drive(1, 24'h012345, 2'd0, 0, 32'h0, acc("R8 io long read second half", 3, 23'h0C0002, 2'd1, 0, 32'h0));
        drive(0, 24'h0, 2'd0, 0, 32'h0, idle("R8 request during stall ignored"));
        begin
            exp_t e = acc("R8 io long write first half", 3, 23'h0C000C, 2'd1, 1, 32'h00001234);
            e.ready = 0;
            drive(1, 24'h3C000C, 2'd2, 1, 32'h12345678, e);
        end
        drive(0, 24'h0, 2'd0, 0, 32'h0, acc("R8 io long write second half", 3, 23'h0C000E, 2'd1, 1, 32'h00005678));
        drive(1, 24'h3C0002, 2'd1, 1, 32'h0000ABCD, acc("R10 io word write not split", 3, 23'h0C0002, 2'd1, 1, 32'h0000ABCD));
        drive(1, 24'h320001, 2'd0, 0, 32'h0, acc("R1 io byte read", 3, 23'h020001, 2'd0, 0, 32'h0));
        drive(0, 24'h0, 2'd0, 0, 32'h0, idle("R1 idle after request"));
        drive(0, 24'h0, 2'd0, 0, 32'h0, idle("R1 idle"));

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule